// File: doc/BRIEF.md
# Station Address Bank with Clock-Domain Handoff

This block keeps a small bank of 48-bit station addresses. Software on a host clock writes each entry as two 32-bit words through a plain register write port with byte enables. The logic that uses the addresses runs on a separate network clock. Each entry has an upper word that carries bits 47:32 in its low 16 bits, and a lower word that carries bits 31:0. Software may write either word at any time. Those writes only change the host-side staging copy, and reads on the host side always return that staging copy.

A new address reaches the network clock domain only when a write to the lower word of an entry covers one chosen byte lane. When the endianness strap is low (little-endian), that lane is bits 31:24. When the strap is high (big-endian), it is bits 7:0. On that write the full 48-bit value is captured into a hold register, with the write's own bytes included, and a per-entry toggle flips. The network side passes the toggle through a two-flop synchronizer and detects the edge. It then loads the held 48 bits in one cycle, so a half-updated address is never visible.

The port carries register accesses and no data stream. There is therefore no valid/ready handshake and no back-pressure. A write completes in the cycle `wr_en` is high. Software must space triggering writes to the same entry at least four network-clock cycles apart.

Top module: `stn_addr_xfer`

## Requirements
- R1: After reset, every network-side address output is zero and every host-side read returns zero.
- R2: Word address bit 0 selects the half of an entry: 0 is the lower word (bits 31:0) and 1 is the upper word (bits 47:32 in read/write bits 15:0). Address bits above bit 0 give the entry index. A read returns the staging value with only the enabled bytes of past writes applied, and an upper-word read returns zero in bits 31:16.
- R3: A write to an upper word never changes any network-side output.
- R4: With the strap low (little-endian), a lower-word write starts a transfer exactly when byte enable 3 (bits 31:24) is set. Lower-word writes without it leave the outputs unchanged.
- R5: With the strap high (big-endian), a lower-word write starts a transfer exactly when byte enable 0 (bits 7:0) is set. Lower-word writes without it leave the outputs unchanged.
- R6: After a transfer, the entry's output equals {upper[15:0], lower[31:0]} as it stood just after the triggering write. Later non-triggering writes do not alter it.
- R7: The output reaches its new value no later than five network-clock edges after the host edge of the triggering write. Between transfers it holds steady, and each transfer loads in a single network-clock cycle.
- R8: A transfer in one entry leaves every other entry's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Host-side clock |
| src_rst_n | input | 1 | Host-side asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | $clog2(N_ENTRY)+1 | Write word address (bit 0: 0 lower, 1 upper) |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables, bit k covers bits 8k+7:8k |
| big_endian | input | 1 | Strap: 0 arms on lane 31:24, 1 arms on lane 7:0 |
| rd_addr | input | $clog2(N_ENTRY)+1 | Read word address |
| rd_data | output | 32 | Staging value at rd_addr |
| dst_clk | input | 1 | Network-side clock |
| dst_rst_n | input | 1 | Network-side asynchronous reset, active low |
| dst_addr | output | 48*N_ENTRY | Synchronized addresses, entry i in bits 48i+47:48i |

## Verification
The transfer function is driven with lower-word writes whose byte-enable patterns include the arming lane under one strap value but not under the other. This separates a block that decodes the lane from the strap from one that fires on any lower-word write. Upper-word-only writes show that a trigger taken from the wrong half is caught. A non-arming write issued right after a triggering one shows whether the network side loads the snapshot or the live staging value. Random mixes of entries, halves, data, enables and strap check that unrelated entries never move and that the captured value includes the triggering write's own bytes.

// File: rtl/stn_addr_pkg.sv
package stn_addr_pkg;
  localparam int ADDR_BITS = 48;
  localparam int WORD_BITS = 32;
  localparam int HI_BITS   = ADDR_BITS - WORD_BITS;
  localparam int LANES     = WORD_BITS / 8;
  localparam int HI_LANES  = HI_BITS / 8;

  // Byte lane that arms a transfer for the given strap value.
  function automatic logic arm_lane_hit(input logic [LANES-1:0] be, input logic big_end);
    return big_end ? be[0] : be[LANES-1];
  endfunction
endpackage

// File: rtl/stn_src_entry.sv
module stn_src_entry
  import stn_addr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_lo,
  input  logic                 sel_hi,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic [LANES-1:0]     wr_be,
  input  logic                 big_end,
  output logic [HI_BITS-1:0]   stage_hi,
  output logic [WORD_BITS-1:0] stage_lo,
  output logic [ADDR_BITS-1:0] hold,
  output logic                 tgl
);
  logic [WORD_BITS-1:0] lo_next;
  logic [HI_BITS-1:0]   hi_next;
  logic                 arm;

  for (genvar b = 0; b < LANES; b++) begin : g_lo_lane
    assign lo_next[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : stage_lo[b*8 +: 8];
  end
  for (genvar b = 0; b < HI_LANES; b++) begin : g_hi_lane
    assign hi_next[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : stage_hi[b*8 +: 8];
  end

  assign arm = sel_lo && arm_lane_hit(wr_be, big_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_hi <= '0;
      stage_lo <= '0;
      hold     <= '0;
      tgl      <= 1'b0;
    end else begin
      if (sel_hi) stage_hi <= hi_next;
      if (sel_lo) stage_lo <= lo_next;
      if (arm) begin
        hold <= {stage_hi, lo_next};
        tgl  <= ~tgl;
      end
    end
  end
endmodule

// File: rtl/stn_dst_entry.sv
module stn_dst_entry
  import stn_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tgl_in,
  input  logic [ADDR_BITS-1:0] hold,
  output logic [ADDR_BITS-1:0] q,
  output logic                 ld
);
  localparam int CHAIN = SYNC_STAGES + 1;
  logic [CHAIN-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[CHAIN-2:0], tgl_in};
  end

  assign ld = sync_q[CHAIN-1] ^ sync_q[CHAIN-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= hold;
  end
endmodule

// File: rtl/stn_addr_xfer.sv
module stn_addr_xfer
  import stn_addr_pkg::*;
#(
  parameter int N_ENTRY     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1,
  localparam int WA_W       = IDX_W + 1
) (
  input  logic                         src_clk,
  input  logic                         src_rst_n,
  input  logic                         wr_en,
  input  logic [WA_W-1:0]              wr_addr,
  input  logic [WORD_BITS-1:0]         wr_data,
  input  logic [LANES-1:0]             wr_be,
  input  logic                         big_endian,
  input  logic [WA_W-1:0]              rd_addr,
  output logic [WORD_BITS-1:0]         rd_data,
  input  logic                         dst_clk,
  input  logic                         dst_rst_n,
  output logic [N_ENTRY*ADDR_BITS-1:0] dst_addr
);
  logic [HI_BITS-1:0]   hi_arr [N_ENTRY];
  logic [WORD_BITS-1:0] lo_arr [N_ENTRY];
  logic [N_ENTRY-1:0]   src_tgl;
  logic [N_ENTRY-1:0]   dst_ld;
  logic [IDX_W-1:0]     wr_idx;
  logic [IDX_W-1:0]     rd_idx;

  assign wr_idx = wr_addr[WA_W-1:1];
  assign rd_idx = rd_addr[WA_W-1:1];

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_entry
    logic [ADDR_BITS-1:0] hold_w;
    logic                 hit;
    assign hit = wr_en && (wr_idx == IDX_W'(i));

    stn_src_entry u_src (
      .clk(src_clk), .rst_n(src_rst_n),
      .sel_lo(hit && !wr_addr[0]), .sel_hi(hit && wr_addr[0]),
      .wr_data(wr_data), .wr_be(wr_be), .big_end(big_endian),
      .stage_hi(hi_arr[i]), .stage_lo(lo_arr[i]),
      .hold(hold_w), .tgl(src_tgl[i])
    );

    stn_dst_entry #(.SYNC_STAGES(SYNC_STAGES)) u_dst (
      .clk(dst_clk), .rst_n(dst_rst_n),
      .tgl_in(src_tgl[i]), .hold(hold_w),
      .q(dst_addr[i*ADDR_BITS +: ADDR_BITS]), .ld(dst_ld[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_ENTRY; i++) begin
      if (rd_idx == IDX_W'(i))
        rd_data = rd_addr[0] ? {{(WORD_BITS-HI_BITS){1'b0}}, hi_arr[i]} : lo_arr[i];
    end
  end
endmodule

// File: rtl/stn_addr_xfer_chk.sv
module stn_addr_xfer_chk
  import stn_addr_pkg::*;
#(
  parameter int N_ENTRY = 4,
  parameter int WA_W    = 3
) (
  input logic                         src_clk,
  input logic                         src_rst_n,
  input logic                         dst_clk,
  input logic                         dst_rst_n,
  input logic                         wr_en,
  input logic [WA_W-1:0]              wr_addr,
  input logic [WA_W-1:0]              rd_addr,
  input logic [WORD_BITS-1:0]         rd_data,
  input logic [N_ENTRY-1:0]           src_tgl,
  input logic [N_ENTRY-1:0]           dst_ld,
  input logic [N_ENTRY*ADDR_BITS-1:0] dst_addr
);
  assert_src_reset_R1: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    $rose(src_rst_n) |-> rd_data == '0);

  assert_dst_reset_R1: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $rose(dst_rst_n) |-> dst_addr == '0);

  assert_hi_pad_R2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    rd_addr[0] |-> rd_data[WORD_BITS-1:HI_BITS] == '0);

  assert_hi_no_arm_R3: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    (wr_en && wr_addr[0]) |=> $stable(src_tgl));

  for (genvar i = 0; i < N_ENTRY; i++) begin : g_chk
    assert_hold_idle_R7: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      !dst_ld[i] |=> $stable(dst_addr[i*ADDR_BITS +: ADDR_BITS]));
    assert_one_load_R7: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      dst_ld[i] |=> !dst_ld[i]);
  end
endmodule

bind stn_addr_xfer stn_addr_xfer_chk #(.N_ENTRY(N_ENTRY), .WA_W(WA_W)) u_chk (
  .src_clk(src_clk), .src_rst_n(src_rst_n), .dst_clk(dst_clk), .dst_rst_n(dst_rst_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_data(rd_data),
  .src_tgl(src_tgl), .dst_ld(dst_ld), .dst_addr(dst_addr)
);

// File: tb/sim_stn_addr_xfer.sv
`timescale 1ns/1ps
module sim_stn_addr_xfer;
  localparam int N = 4;
  localparam int WA = 3;

  logic src_clk = 0, dst_clk = 0, src_rst_n = 0, dst_rst_n = 0;
  logic wr_en = 0, big_endian = 0;
  logic [WA-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic [31:0] rd_data;
  logic [N*48-1:0] dst_addr;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] m_hi [N];
  logic [31:0] m_lo [N];
  logic [47:0] m_out [N];

  always #10 src_clk = ~src_clk;
  always #6.5 dst_clk = ~dst_clk;

  stn_addr_xfer #(.N_ENTRY(N)) u0 (.*);

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic bit arms(logic [3:0] be, logic big);
    return big ? be[0] : be[3];
  endfunction

  task automatic chk(string req, logic [47:0] got, logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_outs(string req);
    for (int i = 0; i < N; i++) chk(req, dst_addr[i*48 +: 48], m_out[i]);
  endtask

  task automatic chk_read(string req, int e, bit hi);
    @(negedge src_clk);
    rd_addr = WA'({e[1:0], hi});
    #1;
    chk(req, {16'h0, rd_data}, hi ? {32'h0, 16'h0, m_hi[e]} : {16'h0, m_lo[e]});
  endtask

  task automatic wr(int e, bit hi, logic [31:0] d, logic [3:0] be);
    @(negedge src_clk);
    wr_en = 1; wr_addr = WA'({e[1:0], hi}); wr_data = d; wr_be = be;
    @(negedge src_clk);
    wr_en = 0;
    if (hi) m_hi[e] = merge({16'h0, m_hi[e]}, d, be & 4'b0011) [15:0];
    else begin
      m_lo[e] = merge(m_lo[e], d, be);
      if (arms(be, big_endian)) m_out[e] = {m_hi[e], m_lo[e]};
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge dst_clk);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog timeout");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin m_hi[i] = 0; m_lo[i] = 0; m_out[i] = 0; end
    #45; src_rst_n = 1; dst_rst_n = 1;
    repeat (2) @(negedge dst_clk);
    chk_outs("R1 reset outputs");
    for (int e = 0; e < N; e++) begin chk_read("R1 reset read", e, 0); chk_read("R1 reset read", e, 1); end

    // R3: upper word writes alone
    wr(0, 1, 32'hFFFF_A1B2, 4'b1111); settle(); chk_outs("R3 high-only write");
    chk_read("R2 high read pad", 0, 1);

    // R4: little-endian
    big_endian = 0;
    wr(0, 0, 32'h1122_3344, 4'b0111); settle(); chk_outs("R4 LE no lane3");
    chk_read("R2 partial bytes", 0, 0);
    wr(0, 0, 32'h5500_0000, 4'b1000); settle(); chk_outs("R4 LE lane3 arms");
    chk("R6 value incl. trigger bytes", dst_addr[47:0], 48'hA1B2_5522_3344);

    // R5: big-endian
    big_endian = 1;
    wr(1, 1, 32'h0000_C0DE, 4'b0011);
    wr(1, 0, 32'hDEAD_BEEF, 4'b1110); settle(); chk_outs("R5 BE no lane0");
    wr(1, 0, 32'h0000_0077, 4'b0001); settle(); chk_outs("R5 BE lane0 arms");

    // R6: snapshot not disturbed by a following non-arming write
    wr(2, 1, 32'h0000_1234, 4'b0011);
    wr(2, 0, 32'hCAFE_F00D, 4'b1111);
    wr(2, 0, 32'h9999_9900, 4'b1110);
    settle(); chk_outs("R6 snapshot");
    chk("R6 entry2", dst_addr[2*48 +: 48], 48'h1234_CAFE_F00D);

    // R7: latency bound
    big_endian = 0;
    wr(3, 0, 32'hABCD_0001, 4'b1000);
    lat = 0;
    while (dst_addr[3*48 +: 48] !== m_out[3] && lat < 10) begin @(negedge dst_clk); lat++; end
    chk("R7 latency<=5", 48'(lat <= 5), 48'h1);
    chk_outs("R8 others untouched");

    // random
    for (int k = 0; k < 300; k++) begin
      int e = $urandom_range(N-1);
      bit hi = $urandom_range(1);
      big_endian = $urandom_range(1);
      wr(e, hi, $urandom, 4'($urandom));
      settle();
      chk_outs(hi ? "R3 random" : (big_endian ? "R5 random" : "R4 random"));
      chk_read("R2 random read", e, hi);
    end
    chk_outs("R8 final");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule